// File: doc/BRIEF.md
# Variable-Length Instruction Stream Decoder

This block sits at the front of a small processor pipeline. It takes instruction bytes one at a time over a valid/ready handshake. It finds where each packed, variable-length instruction begins and ends, and it hands out one decoded record per instruction over a second valid/ready handshake. The high nibble of the first byte fixes both the size of the instruction and where its operands sit. An instruction is one, two, nine or ten bytes long.

Each record holds the following fields:

- the opcode and the function/condition nibble,
- the two register selectors,
- a 64-bit constant assembled least significant byte first,
- the instruction length,
- the address of the instruction and the address of the one after it,
- a status code.

The address counter starts at a value sampled while reset is asserted. A zero byte decodes as a halt. After a halt record or an invalid-instruction record has been handed over, the decoder takes no further bytes until it is reset. Executing instructions, reading registers and accessing memory are outside this block.

Top module: `instr_stream_decoder`

## Requirements
- R1: While reset is low, and right after it is released, `inReady` is 1 and `outValid` is 0. The first record reports `outPc` equal to the `startAddr` value present during reset.
- R2: For byte 0 of each instruction, `outOpcode` reports bits 7:4 and `outFunc` reports bits 3:0.
- R3: The instruction length follows from the opcode:
  - opcodes 0, 1 and 9 take 1 byte;
  - opcodes 2, 6, A and B take 2 bytes (a register byte follows);
  - opcodes 7 and 8 take 9 bytes (an 8-byte constant follows);
  - opcodes 3, 4 and 5 take 10 bytes (a register byte, then an 8-byte constant).
- R4: For instructions with a register byte, `outRegA` reports bits 7:4 of that byte and `outRegB` reports bits 3:0. Instructions without a register byte report F (no register) in both fields.
- R5: The constant is assembled little-endian: the first constant byte received lands in bits 7:0 of `outConst`. Records without a constant report `outConst` = 0.
- R6: `outNextPc` equals `outPc` plus `outLength`. After an accepted record with OK status, the next record's `outPc` equals the previous `outNextPc`.
- R7: While a record is pending (`outValid` high), `inReady` is 0. The record's fields stay unchanged until `outReady` is seen high. A byte offered during that time is taken only after the handoff, and it is not lost.
- R8: Status encoding: 0 = OK, 1 = halt, 2 = invalid. Byte 0x00 yields a 1-byte record with status 1. Once that record is accepted, `inReady` and `outValid` stay 0 until reset.
- R9: An opcode above B yields a 1-byte record with status 2, with both register fields F and constant 0. The decoder then stops as in R8.
- R10: Opcodes 0, 1, 3, 4, 5, 8, 9, A and B must have a zero function nibble. A nonzero one yields a 1-byte record with status 2, with no further bytes taken for it, and the decoder then stops.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| startAddr | input | ADDR_W | Address of the first instruction, sampled during reset |
| inData | input | 8 | Instruction byte |
| inValid | input | 1 | `inData` holds a byte |
| inReady | output | 1 | Decoder takes the byte this cycle |
| outValid | output | 1 | Decoded record available |
| outReady | input | 1 | Consumer takes the record this cycle |
| outOpcode | output | 4 | Opcode nibble |
| outFunc | output | 4 | Function or condition nibble |
| outRegA | output | 4 | First register selector, F = none |
| outRegB | output | 4 | Second register selector, F = none |
| outConst | output | 64 | Little-endian constant, 0 if absent |
| outLength | output | 4 | Instruction length in bytes |
| outStatus | output | 2 | 0 OK, 1 halt, 2 invalid |
| outPc | output | ADDR_W | Address of this instruction |
| outNextPc | output | ADDR_W | Address of the following instruction |

## Verification
The two functions that can fall in the same cycle are the handoff of a finished record and the offer of the first byte of the next instruction. The bench provokes this by running a byte sender and a record consumer at the same time. The consumer holds `outReady` low for several cycles while the sender keeps its byte valid. During that wait the bench requires `inReady` to stay low and the record fields to stay frozen. Once the handoff happens, the next record must carry the held byte and the chained address, which shows that no byte was swallowed or duplicated across the handoff.

// File: rtl/isd_pkg.sv
package isd_pkg;
  localparam int CONST_BYTES = 8;
  localparam int CONST_W = 8 * CONST_BYTES;
  localparam int LEN_W = 4;
  localparam logic [3:0] NO_REG = 4'hF;

  typedef enum logic [1:0] {
    ST_OK   = 2'd0,
    ST_HALT = 2'd1,
    ST_BAD  = 2'd2
  } stat_e;

  typedef struct packed {
    logic capture;
    logic [LEN_W-1:0] index;
    logic advance;
  } ctrlStrobes_t;

  function automatic logic hasRegByte(input logic [3:0] op);
    case (op)
      4'h2, 4'h3, 4'h4, 4'h5, 4'h6, 4'hA, 4'hB: hasRegByte = 1'b1;
      default: hasRegByte = 1'b0;
    endcase
  endfunction

  function automatic logic [LEN_W-1:0] rawLen(input logic [3:0] op);
    case (op)
      4'h2, 4'h6, 4'hA, 4'hB: rawLen = LEN_W'(2);
      4'h7, 4'h8:             rawLen = LEN_W'(1 + CONST_BYTES);
      4'h3, 4'h4, 4'h5:       rawLen = LEN_W'(2 + CONST_BYTES);
      default:                rawLen = LEN_W'(1);
    endcase
  endfunction

  function automatic stat_e headStatus(input logic [7:0] b);
    logic fnFree;
    fnFree = (b[7:4] == 4'h2) || (b[7:4] == 4'h6) || (b[7:4] == 4'h7);
    if (b[7:4] > 4'hB) headStatus = ST_BAD;
    else if (!fnFree && (b[3:0] != 4'h0)) headStatus = ST_BAD;
    else if (b[7:4] == 4'h0) headStatus = ST_HALT;
    else headStatus = ST_OK;
  endfunction

  function automatic logic [LEN_W-1:0] headLen(input logic [7:0] b);
    if (headStatus(b) == ST_BAD) headLen = LEN_W'(1);
    else headLen = rawLen(b[7:4]);
  endfunction
endpackage

// File: rtl/isd_ctrl.sv
module isd_ctrl
  import isd_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic [7:0]         inData,
  input  logic               inValid,
  input  logic               outReady,
  input  logic [LEN_W-1:0]   curLen,
  input  stat_e              curStatus,
  output logic               inReady,
  output logic               outValid,
  output ctrlStrobes_t       strobes
);
  typedef enum logic [1:0] {S_HEAD, S_BODY, S_EMIT, S_STOP} state_e;

  state_e state;
  logic [LEN_W-1:0] idxReg;
  logic take;
  logic lastBody;

  assign inReady  = (state == S_HEAD) || (state == S_BODY);
  assign outValid = (state == S_EMIT);
  assign take     = inValid && inReady;
  assign lastBody = (idxReg == curLen - LEN_W'(1));

  always_comb begin
    strobes.capture = take;
    strobes.index   = (state == S_HEAD) ? '0 : idxReg;
    strobes.advance = outValid && outReady;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state  <= S_HEAD;
      idxReg <= '0;
    end else begin
      case (state)
        S_HEAD: if (take) begin
          idxReg <= LEN_W'(1);
          state  <= (headLen(inData) == LEN_W'(1)) ? S_EMIT : S_BODY;
        end
        S_BODY: if (take) begin
          if (lastBody) state <= S_EMIT;
          else idxReg <= idxReg + LEN_W'(1);
        end
        S_EMIT: if (outReady) begin
          state <= (curStatus == ST_OK) ? S_HEAD : S_STOP;
        end
        default: state <= S_STOP;
      endcase
    end
  end
endmodule

// File: rtl/isd_datapath.sv
module isd_datapath
  import isd_pkg::*;
#(
  parameter int ADDR_W = 64
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [ADDR_W-1:0]  startAddr,
  input  logic [7:0]         inData,
  input  ctrlStrobes_t       strobes,
  output logic [3:0]         opcode,
  output logic [3:0]         func,
  output logic [3:0]         regA,
  output logic [3:0]         regB,
  output logic [CONST_W-1:0] constVal,
  output logic [LEN_W-1:0]   length,
  output stat_e              status,
  output logic [ADDR_W-1:0]  pc,
  output logic [ADDR_W-1:0]  nextPc
);
  logic headByte;
  logic regPhase;
  logic [LEN_W-1:0] constPos;
  logic [7:0] constLane [CONST_BYTES];

  assign headByte = strobes.capture && (strobes.index == '0);
  assign regPhase = hasRegByte(opcode) && (strobes.index == LEN_W'(1));
  assign constPos = strobes.index - (hasRegByte(opcode) ? LEN_W'(2) : LEN_W'(1));
  assign nextPc   = pc + ADDR_W'(length);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pc     <= startAddr;
      opcode <= '0;
      func   <= '0;
      regA   <= NO_REG;
      regB   <= NO_REG;
      length <= LEN_W'(1);
      status <= ST_OK;
    end else begin
      if (headByte) begin
        opcode <= inData[7:4];
        func   <= inData[3:0];
        regA   <= NO_REG;
        regB   <= NO_REG;
        length <= headLen(inData);
        status <= headStatus(inData);
      end else if (strobes.capture && regPhase) begin
        regA <= inData[7:4];
        regB <= inData[3:0];
      end
      if (strobes.advance) pc <= nextPc;
    end
  end

  for (genvar g = 0; g < CONST_BYTES; g++) begin : g_lane
    always_ff @(posedge clk) begin
      if (!rstN || headByte) constLane[g] <= '0;
      else if (strobes.capture && !regPhase && constPos == LEN_W'(g))
        constLane[g] <= inData;
    end
    assign constVal[8*g +: 8] = constLane[g];
  end
endmodule

// File: rtl/instr_stream_decoder.sv
module instr_stream_decoder
  import isd_pkg::*;
#(
  parameter int ADDR_W = 64
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] startAddr,
  input  logic [7:0]        inData,
  input  logic              inValid,
  output logic              inReady,
  output logic              outValid,
  input  logic              outReady,
  output logic [3:0]        outOpcode,
  output logic [3:0]        outFunc,
  output logic [3:0]        outRegA,
  output logic [3:0]        outRegB,
  output logic [63:0]       outConst,
  output logic [3:0]        outLength,
  output logic [1:0]        outStatus,
  output logic [ADDR_W-1:0] outPc,
  output logic [ADDR_W-1:0] outNextPc
);
  ctrlStrobes_t strobes;
  stat_e status;
  logic [LEN_W-1:0] length;
  logic [CONST_W-1:0] constVal;

  isd_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .inData(inData), .inValid(inValid),
    .outReady(outReady), .curLen(length), .curStatus(status),
    .inReady(inReady), .outValid(outValid), .strobes(strobes)
  );

  isd_datapath #(.ADDR_W(ADDR_W)) u_dp (
    .clk(clk), .rstN(rstN), .startAddr(startAddr), .inData(inData),
    .strobes(strobes), .opcode(outOpcode), .func(outFunc),
    .regA(outRegA), .regB(outRegB), .constVal(constVal),
    .length(length), .status(status), .pc(outPc), .nextPc(outNextPc)
  );

  assign outConst  = 64'(constVal);
  assign outLength = 4'(length);
  assign outStatus = status;
endmodule

// File: rtl/isd_checker.sv
module isd_checker #(
  parameter int ADDR_W = 64
) (
  input logic              clk,
  input logic              rstN,
  input logic              inReady,
  input logic              outValid,
  input logic              outReady,
  input logic [3:0]        outRegA,
  input logic [63:0]       outConst,
  input logic [3:0]        outLength,
  input logic [1:0]        outStatus,
  input logic [ADDR_W-1:0] outPc,
  input logic [ADDR_W-1:0] outNextPc
);
  a_r7_no_take_while_pending: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> !inReady);

  a_r7_record_frozen: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !outReady) |=> (outValid && $stable(outConst) && $stable(outPc)
                                 && $stable(outLength) && $stable(outRegA)));

  a_r6_address_chain: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && outReady && outStatus == 2'd0) |=> (outPc == $past(outNextPc)));

  a_r8_stop_after_end: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && outReady && outStatus != 2'd0) |=> (!inReady && !outValid));

  a_r3_legal_length: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> (outLength == 4'd1 || outLength == 4'd2 || outLength == 4'd9
                  || outLength == 4'd10));

  a_r9_bad_is_short: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && outStatus == 2'd2) |-> (outLength == 4'd1 && outConst == 64'd0));
endmodule

bind instr_stream_decoder isd_checker #(.ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/instr_stream_decoder_tb.sv
`timescale 1ns/1ps
module instr_stream_decoder_tb;
  localparam int ADDR_W = 64;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [ADDR_W-1:0] startAddr = '0;
  logic [7:0] inData = '0;
  logic inValid = 1'b0;
  logic outReady = 1'b0;
  logic inReady, outValid;
  logic [3:0] outOpcode, outFunc, outRegA, outRegB, outLength;
  logic [63:0] outConst;
  logic [1:0] outStatus;
  logic [ADDR_W-1:0] outPc, outNextPc;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  instr_stream_decoder #(.ADDR_W(ADDR_W)) u_dut (.*);

  task automatic checkEq(input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic doReset(input logic [ADDR_W-1:0] addr);
    @(negedge clk);
    rstN = 1'b0; startAddr = addr; inValid = 1'b0; outReady = 1'b0;
    repeat (2) @(negedge clk);
    checkEq("R1", "inReady in reset", 64'(inReady), 64'd1);
    checkEq("R1", "outValid in reset", 64'(outValid), 64'd0);
    rstN = 1'b1;
    @(negedge clk);
    checkEq("R1", "inReady after reset", 64'(inReady), 64'd1);
    checkEq("R1", "outValid after reset", 64'(outValid), 64'd0);
  endtask

  task automatic pushByte(input logic [7:0] b);
    @(negedge clk);
    inData = b; inValid = 1'b1;
    while (!inReady) @(negedge clk);
    @(posedge clk);
    #1 inValid = 1'b0;
  endtask

  task automatic pushConst(input logic [63:0] v);
    for (int i = 0; i < 8; i++) pushByte(v[8*i +: 8]);
  endtask

  task automatic popRec(input string req, input logic [3:0] op, input logic [3:0] fn,
                        input logic [3:0] ra, input logic [3:0] rb, input logic [63:0] cst,
                        input logic [3:0] len, input logic [63:0] pc, input logic [1:0] st,
                        input int hold);
    int w = 0;
    @(negedge clk);
    while (!outValid && w < 200) begin @(negedge clk); w++; end
    checkEq(req, "record appears", 64'(outValid), 64'd1);
    for (int i = 0; i < hold; i++) begin
      checkEq("R7", "inReady low while pending", 64'(inReady), 64'd0);
      @(negedge clk);
      checkEq("R7", "record still held", 64'(outValid), 64'd1);
    end
    checkEq("R2", "opcode", 64'(outOpcode), 64'(op));
    checkEq("R2", "function", 64'(outFunc), 64'(fn));
    checkEq("R4", "regA", 64'(outRegA), 64'(ra));
    checkEq("R4", "regB", 64'(outRegB), 64'(rb));
    checkEq("R5", "constant", outConst, cst);
    checkEq("R3", "length", 64'(outLength), 64'(len));
    checkEq("R6", "pc", 64'(outPc), pc);
    checkEq("R6", "next pc", 64'(outNextPc), pc + 64'(len));
    checkEq(req, "status", 64'(outStatus), 64'(st));
    outReady = 1'b1;
    @(posedge clk);
    #1 outReady = 1'b0;
  endtask

  task automatic checkStopped(input string req);
    @(negedge clk);
    inData = 8'h10; inValid = 1'b1;
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      checkEq(req, "no byte taken after stop", 64'(inReady), 64'd0);
      checkEq(req, "no record after stop", 64'(outValid), 64'd0);
    end
    inValid = 1'b0;
  endtask

  task automatic testShortForms();
    pushByte(8'h10);
    popRec("R3", 4'h1, 4'h0, 4'hF, 4'hF, 64'd0, 4'd1, 64'h100, 2'd0, 0);
    pushByte(8'h61); pushByte(8'h37);
    popRec("R4", 4'h6, 4'h1, 4'h3, 4'h7, 64'd0, 4'd2, 64'h101, 2'd0, 0);
  endtask

  task automatic testConstForms();
    pushByte(8'h74); pushConst(64'h84);
    popRec("R5", 4'h7, 4'h4, 4'hF, 4'hF, 64'h84, 4'd9, 64'h103, 2'd0, 0);
    pushByte(8'h30); pushByte(8'hF2); pushConst(64'h8877665544332211);
    popRec("R5", 4'h3, 4'h0, 4'hF, 4'h2, 64'h8877665544332211, 4'd10, 64'h10C, 2'd0, 0);
    pushByte(8'h40); pushByte(8'h5C); pushConst(64'hFFFFFFFFFFFFFFF0);
    popRec("R5", 4'h4, 4'h0, 4'h5, 4'hC, 64'hFFFFFFFFFFFFFFF0, 4'd10, 64'h116, 2'd0, 0);
    pushByte(8'hA0); pushByte(8'h3F);
    popRec("R4", 4'hA, 4'h0, 4'h3, 4'hF, 64'd0, 4'd2, 64'h120, 2'd0, 0);
  endtask

  task automatic testOverlap();
    fork
      begin pushByte(8'h90); pushByte(8'h25); pushByte(8'h13); end
      begin
        popRec("R7", 4'h9, 4'h0, 4'hF, 4'hF, 64'd0, 4'd1, 64'h122, 2'd0, 4);
        popRec("R7", 4'h2, 4'h5, 4'h1, 4'h3, 64'd0, 4'd2, 64'h123, 2'd0, 3);
      end
    join
  endtask

  task automatic testHalt();
    pushByte(8'h00);
    popRec("R8", 4'h0, 4'h0, 4'hF, 4'hF, 64'd0, 4'd1, 64'h125, 2'd1, 1);
    checkStopped("R8");
  endtask

  task automatic testBadOpcode();
    doReset(64'h2000);
    pushByte(8'hC0);
    popRec("R9", 4'hC, 4'h0, 4'hF, 4'hF, 64'd0, 4'd1, 64'h2000, 2'd2, 0);
    checkStopped("R9");
  endtask

  task automatic testBadFunc();
    doReset(64'h40);
    pushByte(8'h35);
    popRec("R10", 4'h3, 4'h5, 4'hF, 4'hF, 64'd0, 4'd1, 64'h40, 2'd2, 0);
    checkStopped("R10");
    doReset(64'h50);
    pushByte(8'h01);
    popRec("R10", 4'h0, 4'h1, 4'hF, 4'hF, 64'd0, 4'd1, 64'h50, 2'd2, 0);
    checkStopped("R10");
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    doReset(64'h100);
    testShortForms();
    testConstForms();
    testOverlap();
    testHalt();
    testBadOpcode();
    testBadFunc();
    finishRun();
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finishRun();
  end
endmodule